// File: doc/BRIEF.md
# Keyed Watchdog with Software Reset

This block is a watchdog timer guarded by a single byte-wide key register. Software keeps the watchdog from expiring by writing a two-byte restart key into that register. The same register also takes a second two-byte key that asks for a deliberate reset. Any byte that does not fit either key is treated as a fault, and it resets the chip at once.

Every reset the block makes is a pulse of fixed length on one output. Two sticky flags record the cause. One is the overflow flag and the other is the software-reset flag. A fault sets both flags together. The flags survive the resets the block makes, so boot code can read them. They are cleared only by power-on reset or by a clear strobe.

The timeout is a power-of-two number of counting cycles, picked by a select input. While the CPU is idle, the counter runs only if the idle-run enable is set.

Top module: `wdg_keyed`

## Requirements
- R1: After power-on reset (`rst_n` low), `rst_pulse`, `flag_ovf` and `flag_swr` are all 0.
- R2: With `wdt_en` high and counting uninterrupted, `rst_pulse` rises on the 2^(BASE_LOG+`tmo_sel`)-th clock edge after the edge that took a restart key (defaults: select 0 gives 16, 1 gives 32, 2 gives 64, 3 gives 128).
- R3: Every reset pulse stays high for exactly PULSE_LEN (default 16) clock cycles.
- R4: A timeout sets `flag_ovf` and leaves `flag_swr` unchanged.
- R5: Writing 0x1E and then 0xE1 clears the count and produces no pulse.
- R6: Writing 0x5A and then 0xA5 starts a pulse on the edge that takes 0xA5 and sets only `flag_swr`. A lone 0x5A produces no pulse.
- R7: A first byte other than 0x1E or 0x5A, or a second byte that is not the partner of the accepted first byte (0xE1 after 0x1E, 0xA5 after 0x5A), starts a pulse on the edge that takes that byte and sets both flags.
- R8: While `cpu_idle` is high and `idle_run` is low, the count holds. With `idle_run` high, the count advances during idle.
- R9: While `wdt_en` is low, the count is held at zero and no timeout occurs.
- R10: The flags stay set through and after a pulse. `flag_clr` clears both flags, but an event in the same cycle wins over the clear.
- R11: Key writes made while a pulse is active are ignored, and a pulse discards any half-entered key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| key_we | input | 1 | Write strobe for the key register |
| key_data | input | 8 | Byte written to the key register |
| wdt_en | input | 1 | Watchdog counting enable |
| tmo_sel | input | SEL_W | Timeout select (exponent offset) |
| cpu_idle | input | 1 | CPU is in idle mode |
| idle_run | input | 1 | Let the watchdog count during idle |
| flag_clr | input | 1 | Clear both status flags |
| rst_pulse | output | 1 | Internal reset pulse |
| flag_ovf | output | 1 | Sticky watchdog-overflow flag |
| flag_swr | output | 1 | Sticky software-reset flag |

## Verification
A key write is taken on one clock edge. Any pulse or flag change it causes is visible right after that same edge, so the bench samples on the following falling edge. A timeout is due 2^(BASE_LOG+select) counting edges after the restart edge. The bench counts falling edges from the restart and expects the pulse at exactly that count. The pulse must then stay high for exactly 16 samples. A cycle-level reference model, written from the requirements, is updated on every rising edge with the same inputs. The design's three outputs are compared against it on every falling edge, through directed corner cases and a long seeded random phase.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Restart and reset key bytes; the order within each pair is behaviour.
    localparam logic [7:0] KICK_FIRST = 8'h1E;
    localparam logic [7:0] KICK_LAST  = 8'hE1;
    localparam logic [7:0] SWR_FIRST  = 8'h5A;
    localparam logic [7:0] SWR_LAST   = 8'hA5;

    typedef enum logic [1:0] {
        KEY_IDLE      = 2'd0,
        KEY_WAIT_KICK = 2'd1,
        KEY_WAIT_SWR  = 2'd2
    } key_st_e;

    typedef struct packed {
        logic ovf;
        logic swr;
    } flag_t;

endpackage

// File: rtl/wdg_key_check.sv
module wdg_key_check
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       key_we,
    input  logic [7:0] key_data,
    output logic       ev_kick,
    output logic       ev_swr,
    output logic       ev_err
);

    typedef struct packed {
        key_st_e st;
    } key_reg_t;

    key_reg_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        ev_kick = 1'b0;
        ev_swr  = 1'b0;
        ev_err  = 1'b0;
        if (busy) begin
            r_d.st = KEY_IDLE;               // pulse drops a half-entered key
        end else if (key_we) begin
            unique case (r_q.st)
                KEY_IDLE: begin
                    if (key_data == KICK_FIRST)     r_d.st = KEY_WAIT_KICK;
                    else if (key_data == SWR_FIRST) r_d.st = KEY_WAIT_SWR;
                    else                            ev_err = 1'b1;
                end
                KEY_WAIT_KICK: begin
                    r_d.st = KEY_IDLE;
                    if (key_data == KICK_LAST) ev_kick = 1'b1;
                    else                       ev_err  = 1'b1;
                end
                KEY_WAIT_SWR: begin
                    r_d.st = KEY_IDLE;
                    if (key_data == SWR_LAST) ev_swr = 1'b1;
                    else                      ev_err = 1'b1;
                end
                default: r_d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: KEY_IDLE};
        else        r_q <= r_d;
    end

    AST_KEY_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_kick, ev_swr, ev_err}))
        else $error("more than one key event");                          // R7

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> r_q.st == KEY_IDLE)
        else $error("key state kept across pulse");                      // R11

endmodule

// File: rtl/wdg_tmo_count.sv
module wdg_tmo_count #(
    parameter int BASE_LOG = 4,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             cpu_idle,
    input  logic             idle_run,
    input  logic             ev_kick,
    output logic             ev_tmo
);

    localparam int NSEL = 1 << SEL_W;
    localparam int CW   = BASE_LOG + NSEL;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t      r_q, r_d;
    logic [CW-1:0] lim_m1;
    logic          tick;

    // Terminal count for each select code, one compare per code.
    always_comb begin
        lim_m1 = '0;
        for (int i = 0; i < NSEL; i++) begin
            if (tmo_sel == SEL_W'(i)) lim_m1 = CW'((64'd1 << (BASE_LOG + i)) - 64'd1);
        end
    end

    always_comb begin
        r_d    = r_q;
        tick   = wdt_en && (!cpu_idle || idle_run);
        ev_tmo = !busy && tick && !ev_kick && (r_q.cnt >= lim_m1);
        if (busy || !wdt_en || ev_kick || ev_tmo) r_d.cnt = '0;
        else if (tick)                            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: '0};
        else        r_q <= r_d;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_en && cpu_idle && !idle_run && !busy && !ev_kick) |=> $stable(r_q.cnt))
        else $error("count moved while idle");                           // R8

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> r_q.cnt == '0)
        else $error("count kept while disabled");                        // R9

endmodule

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic rst_pulse
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pg_reg_t;

    pg_reg_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        busy = (r_q.left != '0);
        if (busy)       r_d.left = r_q.left - 1'b1;
        else if (start) r_d.left = PW'(PULSE_LEN);
        rst_pulse = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{left: '0};
        else        r_q <= r_d;
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> rst_pulse)
        else $error("pulse did not start");                              // R2

endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
    import wdg_pkg::*;
#(
    parameter int BASE_LOG  = 4,
    parameter int SEL_W     = 2,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [7:0]       key_data,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             cpu_idle,
    input  logic             idle_run,
    input  logic             flag_clr,
    output logic             rst_pulse,
    output logic             flag_ovf,
    output logic             flag_swr
);

    localparam int RW = $clog2(PULSE_LEN + 2) + 1;

    logic  busy, ev_kick, ev_swr, ev_err, ev_tmo;
    flag_t flags_q, flags_d;

    wdg_key_check i_key (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .key_we(key_we), .key_data(key_data),
        .ev_kick(ev_kick), .ev_swr(ev_swr), .ev_err(ev_err)
    );

    wdg_tmo_count #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wdt_en(wdt_en),
        .tmo_sel(tmo_sel), .cpu_idle(cpu_idle), .idle_run(idle_run),
        .ev_kick(ev_kick), .ev_tmo(ev_tmo)
    );

    wdg_pulse_gen #(.PULSE_LEN(PULSE_LEN)) i_pg (
        .clk(clk), .rst_n(rst_n), .start(ev_tmo | ev_swr | ev_err),
        .busy(busy), .rst_pulse(rst_pulse)
    );

    // Sticky flags: only power-on reset and the clear strobe remove them.
    always_comb begin
        flags_d = flags_q;
        if (flag_clr) flags_d = '{ovf: 1'b0, swr: 1'b0};
        if (ev_tmo || ev_err) flags_d.ovf = 1'b1;
        if (ev_swr || ev_err) flags_d.swr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '{ovf: 1'b0, swr: 1'b0};
        else        flags_q <= flags_d;
    end

    assign flag_ovf = flags_q.ovf;
    assign flag_swr = flags_q.swr;

    // Run-length counter used only by the pulse-length check.
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (rst_pulse) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse) |-> run_q == RW'(PULSE_LEN))
        else $error("pulse length wrong");                               // R3

    AST_KICK_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kick && !rst_pulse) |=> !rst_pulse)
        else $error("restart caused reset");                             // R5

    AST_TMO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmo |=> flag_ovf)
        else $error("overflow flag missing");                            // R4

    AST_SWR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_swr |=> (flag_swr && rst_pulse))
        else $error("software reset not flagged");                       // R6

    AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> (flag_ovf && flag_swr && rst_pulse))
        else $error("bad key not flagged");                              // R7

endmodule

// File: tb/test_wdg_keyed.sv
`timescale 1ns/1ps
module test_wdg_keyed;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_we = 1'b0;
    logic [7:0] key_data = 8'h00;
    logic       wdt_en = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic       cpu_idle = 1'b0;
    logic       idle_run = 1'b0;
    logic       flag_clr = 1'b0;
    logic       rst_pulse, flag_ovf, flag_swr;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wdg_keyed i_wdg_keyed (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
        .wdt_en(wdt_en), .tmo_sel(tmo_sel), .cpu_idle(cpu_idle),
        .idle_run(idle_run), .flag_clr(flag_clr),
        .rst_pulse(rst_pulse), .flag_ovf(flag_ovf), .flag_swr(flag_swr)
    );

    // Reference model built from the requirements, one update per edge.
    int m_st, m_cnt, m_left;
    bit m_ovf, m_swr;

    function automatic int lim_of(input int sel);
        return 1 << (4 + sel);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_left = 0; m_ovf = 0; m_swr = 0;
        end else begin
            bit busy, k, s, e, t, tick;
            busy = (m_left != 0);
            k = 0; s = 0; e = 0;
            if (busy) m_st = 0;
            else if (key_we) begin
                case (m_st)
                    0: if (key_data == 8'h1E) m_st = 1;
                       else if (key_data == 8'h5A) m_st = 2;
                       else e = 1;
                    1: begin m_st = 0; if (key_data == 8'hE1) k = 1; else e = 1; end
                    default: begin m_st = 0; if (key_data == 8'hA5) s = 1; else e = 1; end
                endcase
            end
            tick = wdt_en && (!cpu_idle || idle_run);
            t = !busy && tick && !k && (m_cnt >= lim_of(int'(tmo_sel)) - 1);
            if (busy || !wdt_en || k || t) m_cnt = 0;
            else if (tick) m_cnt = m_cnt + 1;
            if (flag_clr) begin m_ovf = 0; m_swr = 0; end
            if (t || e) m_ovf = 1;
            if (s || e) m_swr = 1;
            if (busy) m_left = m_left - 1;
            else if (t || s || e) m_left = 16;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Continuous comparison against the model on every falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(rst_pulse == (m_left != 0), "R2 R3 model pulse", int'(rst_pulse), int'(m_left != 0));
            chk(flag_ovf == m_ovf, "R4 R7 R10 model ovf", int'(flag_ovf), int'(m_ovf));
            chk(flag_swr == m_swr, "R6 R7 R10 model swr", int'(flag_swr), int'(m_swr));
        end
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk); key_we = 1'b1; key_data = b;
        @(negedge clk); key_we = 1'b0;
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        while (!rst_pulse && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rst_pulse && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, seen;
        void'($urandom(32'd20741));
        idle_n(4);
        chk(!rst_pulse && !flag_ovf && !flag_swr, "R1 reset state", int'({rst_pulse, flag_ovf, flag_swr}), 0);
        rst_n = 1'b1;
        idle_n(2);
        chk(!rst_pulse && !flag_ovf && !flag_swr, "R1 after release", int'({rst_pulse, flag_ovf, flag_swr}), 0);

        // R2, R3, R4, R10: timeout at select 0
        wdt_en = 1'b1; tmo_sel = 2'd0;
        wr(8'h1E); wr(8'hE1);
        wait_pulse(n);
        chk(n == 16, "R2 timeout sel0", n, 16);
        chk(flag_ovf && !flag_swr, "R4 ovf only", int'({flag_ovf, flag_swr}), 2);
        pulse_len(n);
        chk(n == 16, "R3 pulse length", n, 16);
        chk(flag_ovf, "R10 flag kept after pulse", int'(flag_ovf), 1);
        wdt_en = 1'b0;
        clear_flags();
        chk(!flag_ovf && !flag_swr, "R10 clear", int'({flag_ovf, flag_swr}), 0);

        // R2 at select 2
        wdt_en = 1'b1; tmo_sel = 2'd2;
        wr(8'h1E); wr(8'hE1);
        wait_pulse(n);
        chk(n == 64, "R2 timeout sel2", n, 64);
        pulse_len(n);
        wdt_en = 1'b0; clear_flags();

        // R5: regular restarts keep it alive
        wdt_en = 1'b1; tmo_sel = 2'd0; seen = 0;
        for (int i = 0; i < 20; i++) begin
            wr(8'h1E); wr(8'hE1);
            for (int j = 0; j < 10; j++) begin @(negedge clk); if (rst_pulse) seen++; end
        end
        chk(seen == 0, "R5 restarts prevent reset", seen, 0);
        chk(!flag_ovf && !flag_swr, "R5 no flags", int'({flag_ovf, flag_swr}), 0);
        wdt_en = 1'b0;

        // R6: software reset key
        wr(8'h5A);
        chk(!rst_pulse, "R6 first byte alone", int'(rst_pulse), 0);
        wr(8'hA5);
        chk(rst_pulse && flag_swr && !flag_ovf, "R6 software reset", int'({rst_pulse, flag_ovf, flag_swr}), 5);
        pulse_len(n);
        chk(n == 16, "R3 software pulse length", n, 16);
        clear_flags();

        // R7: wrong sequences
        wr(8'h1E); wr(8'hA5);
        chk(rst_pulse && flag_ovf && flag_swr, "R7 crossed pair", int'({rst_pulse, flag_ovf, flag_swr}), 7);
        pulse_len(n); clear_flags();
        wr(8'h33);
        chk(rst_pulse && flag_ovf && flag_swr, "R7 bad first byte", int'({rst_pulse, flag_ovf, flag_swr}), 7);
        pulse_len(n); clear_flags();
        wr(8'h5A); wr(8'hE1);
        chk(rst_pulse && flag_ovf && flag_swr, "R7 bad second byte", int'({rst_pulse, flag_ovf, flag_swr}), 7);
        pulse_len(n); clear_flags();

        // R11: writes during a pulse are ignored; clear works during a pulse
        wr(8'h5A); wr(8'hA5);
        wr(8'h33);
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        pulse_len(n); idle_n(2);
        chk(!rst_pulse && !flag_ovf && !flag_swr, "R11 write in pulse ignored", int'({rst_pulse, flag_ovf, flag_swr}), 0);

        // R8: idle gating
        wdt_en = 1'b1; tmo_sel = 2'd0;
        wr(8'h1E); wr(8'hE1);
        cpu_idle = 1'b1; idle_run = 1'b0; seen = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (rst_pulse) seen++; end
        chk(seen == 0, "R8 idle holds count", seen, 0);
        idle_run = 1'b1;
        wait_pulse(n);
        chk(n == 16, "R8 idle run counts", n, 16);
        pulse_len(n);
        cpu_idle = 1'b0; idle_run = 1'b0; clear_flags();

        // R9: disabled
        wdt_en = 1'b0; seen = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (rst_pulse) seen++; end
        chk(seen == 0 && !flag_ovf, "R9 disabled no timeout", seen, 0);
        wdt_en = 1'b1;
        wait_pulse(n);
        chk(n == 16, "R9 count restarts from zero", n, 16);
        pulse_len(n);

        // Seeded random phase checked by the model
        for (int i = 0; i < 3000; i++) begin
            int act;
            act = int'($urandom_range(0, 9));
            wdt_en   = ($urandom_range(0, 7) != 0);
            cpu_idle = ($urandom_range(0, 3) == 0);
            idle_run = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 15) == 0) tmo_sel = 2'($urandom_range(0, 3));
            case (act)
                0, 1, 2: begin wr(8'h1E); wr(8'hE1); end
                3:       begin wr(8'h5A); wr(8'hA5); end
                4:       wr(8'($urandom_range(0, 255)));
                5:       wr(($urandom_range(0, 1) == 1) ? 8'h1E : 8'h5A);
                6:       clear_flags();
                default: idle_n(int'($urandom_range(1, 20)));
            endcase
        end
        idle_n(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule